// File: doc/BRIEF.md
# Timer and Event Counter with Preload

This block is an up-counter with a reload register. It has three ways of counting. In timer mode it counts ticks of a programmable prescaler that runs from the system clock. In event mode it counts transitions on an external input. In pulse-width mode it counts prescaler ticks for as long as the external input sits at its active level. When the counter passes its top value it wraps to the value held in the reload register. The same overflow can raise an interrupt pulse and toggles a square-wave output, which has a complementary companion pin for driving a buzzer.

Software reaches the block through a plain register bus. One port writes the control register, which is always visible on a read-back port. Another port writes the reload value. A read strobe marks a read of the count, and the count clock is gated off during that cycle. There is no data stream, so there is no valid/ready handshake and no back-pressure. Every bus strobe takes effect in the cycle it is high.

The control register fields are as follows:
- bits 2:0: prescaler select s. A tick occurs once every 2^s system clocks.
- bit 3: polarity.
- bit 4: run.
- bit 5: interrupt enable.
- bits 7:6: mode.

Top module: `tmr_event_counter`

## Requirements
- R1: After reset the count, the reload value and the control register are all 0, `irq` and `fout` are 0, and `fout_n` is 1.
- R2: In timer mode (mode field 2'b10) with run set, the count advances once per prescaler tick. The prescaler is a free-running 7-bit counter that is cleared only by reset, and a tick occurs when its low s bits are all ones, so the division ratio is 2^s for s from 0 to 7.
- R3: In event mode (mode field 2'b01) with run set, the count advances once per active transition of `ext_in`, as seen after two synchroniser flops. Polarity bit 0 selects rising edges and polarity bit 1 selects falling edges. A steady level never advances the count.
- R4: An advance from 8'hFF loads the reload value instead of wrapping to zero, in every mode. With the interrupt-enable bit set, `irq` is high for the cycle after that advance.
- R5: With the interrupt-enable bit clear, `irq` stays low, and overflow reloads and output toggles still take place.
- R6: Each overflow toggles `fout` in the cycle after the advance, and `fout_n` is always its complement.
- R7: A reload write while run is 0 sets both the reload value and the count. A reload write while run is 1 changes only the reload value, which is first used at the next overflow. A write in the same cycle as an overflow lands after that reload.
- R8: In pulse-width mode (mode field 2'b11) the count advances on prescaler ticks while the synchronised input equals the active level (1 when polarity is 0, 0 when polarity is 1). Once the active level has been seen and then ends, the hardware clears run. If the input is inactive when run is set, the block waits for the active level.
- R9: With run 0, or with mode 2'b00, the count never advances. In timer and event modes only a control write clears run.
- R10: In a cycle with `cnt_rd` high, the count does not advance.
- R11: `ctrl_rdata` returns the last value written to the control register, except where the hardware has cleared run as R8 describes. When a control write and that hardware clear fall in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External event or pulse input (asynchronous) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read-back |
| pre_we | input | 1 | Reload register write strobe |
| pre_wdata | input | CNT_W | Reload write data |
| cnt_rd | input | 1 | Count read strobe; gates the count clock |
| cnt_rdata | output | CNT_W | Current count |
| irq | output | 1 | Overflow interrupt pulse |
| fout | output | 1 | Overflow-toggled frequency output |
| fout_n | output | 1 | Complement of fout |

## Verification
The bench uses the default parameters: an 8-bit count, eight prescaler stages and a two-flop synchroniser. With these values, overflow and reload are reached within a few dozen cycles when the reload value is set near the top. The slowest prescaler tap, divide by 128, is still exercised, because a reload value of 8'hFE reaches overflow after only two ticks. The bench keeps a behavioural model of the input synchroniser, the free-running prescaler phase and the hardware clear of run. This lets it compare edge timing and the end of a pulse measurement exactly on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam int CTRL_W   = 8;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 3;
  localparam int POL_BIT  = 3;
  localparam int RUN_BIT  = 4;
  localparam int IE_BIT   = 5;
  localparam int MODE_LSB = 6;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int STAGES = 8,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (STAGES > 1) ? STAGES - 1 : 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // low s bits all ones gives one tick every 2^s clocks
  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(sel)) mask[i] = 1'b1;
    end
    tick = ((div_q & mask) == mask);
  end
endmodule

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic pol,
  output logic level_act,
  output logic edge_act
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign s         = sync_q[STAGES-1];
  assign level_act = s ^ pol;
  assign edge_act  = pol ? (~s & prev_q) : (s & ~prev_q);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         running,
  input  logic         pre_we,
  input  logic [W-1:0] pre_wdata,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] pre_q;

  assign ovf = inc && (cnt_q == {W{1'b1}});
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (pre_we) pre_q <= pre_wdata;
      if (pre_we && !running) cnt_q <= pre_wdata;
      else if (ovf)           cnt_q <= pre_q;
      else if (inc)           cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_STAGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_in,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic              pre_we,
  input  logic [CNT_W-1:0]  pre_wdata,
  input  logic              cnt_rd,
  output logic [CNT_W-1:0]  cnt_rdata,
  output logic              irq,
  output logic              fout,
  output logic              fout_n
);
  logic [CTRL_W-1:0] ctrl_q;
  tmr_mode_e         mode;
  logic              running, pol, irq_en;
  logic              tick, level_act, edge_act;
  logic              inc, ovf, armed_q, pw_done;
  logic              irq_q, fout_q;

  assign mode    = tmr_mode_e'(ctrl_q[MODE_LSB +: 2]);
  assign running = ctrl_q[RUN_BIT];
  assign pol     = ctrl_q[POL_BIT];
  assign irq_en  = ctrl_q[IE_BIT];

  tmr_prescaler #(.STAGES(PSC_STAGES), .SEL_W(SEL_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q[SEL_LSB +: SEL_W]),
    .tick (tick)
  );

  tmr_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (ext_in),
    .pol      (pol),
    .level_act(level_act),
    .edge_act (edge_act)
  );

  always_comb begin
    inc = 1'b0;
    if (running && !cnt_rd) begin
      case (mode)
        MODE_EVENT: inc = edge_act;
        MODE_TIMER: inc = tick;
        MODE_PULSE: inc = tick && level_act;
        default:    inc = 1'b0;
      endcase
    end
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .running  (running),
    .pre_we   (pre_we),
    .pre_wdata(pre_wdata),
    .cnt      (cnt_rdata),
    .ovf      (ovf)
  );

  assign pw_done = running && (mode == MODE_PULSE) && armed_q && !level_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      fout_q  <= 1'b0;
    end else begin
      if (ctrl_we)      ctrl_q          <= ctrl_wdata;
      else if (pw_done) ctrl_q[RUN_BIT] <= 1'b0;

      if (running && (mode == MODE_PULSE) && level_act) armed_q <= 1'b1;
      else if (pw_done || !running || (mode != MODE_PULSE)) armed_q <= 1'b0;

      irq_q <= ovf && irq_en;
      if (ovf) fout_q <= ~fout_q;
    end
  end

  assign ctrl_rdata = ctrl_q;
  assign irq        = irq_q;
  assign fout       = fout_q;
  assign fout_n     = ~fout_q;
endmodule

// File: rtl/tmr_event_counter_chk.sv
module tmr_event_counter_chk #(
  parameter int CNT_W       = 8,
  parameter int PSC_STAGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_in,
  input logic              ctrl_we,
  input logic [7:0]        ctrl_wdata,
  input logic [7:0]        ctrl_rdata,
  input logic              pre_we,
  input logic [CNT_W-1:0]  pre_wdata,
  input logic              cnt_rd,
  input logic [CNT_W-1:0]  cnt_rdata,
  input logic              irq,
  input logic              fout,
  input logic              fout_n
);
  assert_irq_after_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_rdata) == {CNT_W{1'b1}}));

  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[5] && !ctrl_we) |=> !irq);

  assert_fout_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fout) |-> ($past(cnt_rdata) == {CNT_W{1'b1}}));

  assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[4] && !pre_we) |=> $stable(cnt_rdata));

  assert_read_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !pre_we) |=> $stable(cnt_rdata));

  assert_hw_clear_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_rdata[4]) && !$past(ctrl_we)) |-> ($past(ctrl_rdata[7:6]) == 2'b11));
endmodule

bind tmr_event_counter tmr_event_counter_chk #(
  .CNT_W(CNT_W), .PSC_STAGES(PSC_STAGES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tmr_event_counter_test.sv
module tmr_event_counter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_in = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       pre_we = 1'b0;
  logic [7:0] pre_wdata = '0;
  logic       cnt_rd = 1'b0;
  logic [7:0] cnt_rdata;
  logic       irq, fout, fout_n;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  tmr_event_counter uut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .pre_we(pre_we), .pre_wdata(pre_wdata),
    .cnt_rd(cnt_rd), .cnt_rdata(cnt_rdata),
    .irq(irq), .fout(fout), .fout_n(fout_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] m_ctrl = '0, m_cnt = '0, m_pre = '0;
  int  m_psc = 0;
  bit  m_s0 = 0, m_s1 = 0, m_s2 = 0;
  bit  m_fout = 0, m_irq = 0, m_armed = 0;
  int  irq_seen = 0;
  int  m_ovf_total = 0;

  always @(posedge clk) begin
    bit run, pol, ie, tick, act, edg, inc, ovf, done;
    int mode, sel;
    if (!rst_n) begin
      m_ctrl = '0; m_cnt = '0; m_pre = '0; m_psc = 0;
      m_s0 = 0; m_s1 = 0; m_s2 = 0; m_fout = 0; m_irq = 0; m_armed = 0;
    end else begin
      run  = m_ctrl[4];
      pol  = m_ctrl[3];
      ie   = m_ctrl[5];
      mode = int'(m_ctrl[7:6]);
      sel  = int'(m_ctrl[2:0]);
      tick = ((m_psc % (1 << sel)) == ((1 << sel) - 1));
      act  = m_s1 ^ pol;
      edg  = pol ? (!m_s1 && m_s2) : (m_s1 && !m_s2);
      inc  = 0;
      if (run && !cnt_rd) begin
        if (mode == 1) inc = edg;
        else if (mode == 2) inc = tick;
        else if (mode == 3) inc = tick && act;
      end
      ovf  = inc && (m_cnt == 8'hFF);
      done = run && (mode == 3) && m_armed && !act;
      if (ovf) m_ovf_total++;
      m_irq = ovf && ie;
      if (ovf) m_fout = !m_fout;
      if (pre_we && !run) m_cnt = pre_wdata;
      else if (ovf)       m_cnt = m_pre;
      else if (inc)       m_cnt = m_cnt + 8'd1;
      if (pre_we) m_pre = pre_wdata;
      if (run && mode == 3 && act) m_armed = 1;
      else if (done || !run || mode != 3) m_armed = 0;
      if (ctrl_we)   m_ctrl = ctrl_wdata;
      else if (done) m_ctrl[4] = 1'b0;
      m_psc = (m_psc + 1) % 128;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = ext_in;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cnt_rdata == m_cnt, cur_req, cnt_rdata, m_cnt);
    check(ctrl_rdata == m_ctrl, cur_req, ctrl_rdata, m_ctrl);
    check(irq == m_irq, cur_req, irq, m_irq);
    check(fout == m_fout && fout_n == !m_fout, cur_req, {fout, fout_n}, {m_fout, !m_fout});
    if (irq) irq_seen++;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_pre(input logic [7:0] v);
    pre_we = 1'b1; pre_wdata = v;
    step(1);
    pre_we = 1'b0;
  endtask

  task automatic pulse_ext(input int hi, input int lo, input int reps);
    for (int r = 0; r < reps; r++) begin
      ext_in = 1'b1; step(hi);
      ext_in = 1'b0; step(lo);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    int ovf_before;
    repeat (3) @(negedge clk);
    // R1 reset values
    cur_req = "R1";
    check(cnt_rdata == 8'h00, "R1", cnt_rdata, 0);
    check(ctrl_rdata == 8'h00, "R1", ctrl_rdata, 0);
    check(irq == 1'b0 && fout == 1'b0 && fout_n == 1'b1, "R1", {irq, fout, fout_n}, 3'b001);
    rst_n = 1'b1;
    step(2);

    // R7 stopped reload write, R11 readback
    cur_req = "R7";
    wr_ctrl(8'h20);
    wr_pre(8'hF0);
    check(cnt_rdata == 8'hF0, "R7", cnt_rdata, 8'hF0);
    cur_req = "R11";
    check(ctrl_rdata == 8'h20, "R11", ctrl_rdata, 8'h20);

    // R2 timer divide-by-1, R4 overflow reload, R6 toggle
    cur_req = "R2";
    wr_ctrl(8'hB0);
    step(40);
    cur_req = "R4";
    check(irq_seen > 0, "R4", irq_seen, 1);
    cur_req = "R9";
    check(ctrl_rdata[4] == 1'b1, "R9", ctrl_rdata, 8'hB0);
    cur_req = "R2";
    wr_ctrl(8'hB3);
    step(200);
    wr_ctrl(8'hA7);
    wr_pre(8'hFE);
    wr_ctrl(8'hB7);
    step(600);
    cur_req = "R6";
    check(m_ovf_total >= 3, "R6", m_ovf_total, 3);

    // R10 read gating
    cur_req = "R10";
    wr_ctrl(8'hB0);
    for (int k = 0; k < 6; k++) begin
      snap = cnt_rdata;
      cnt_rd = 1'b1; step(1);
      check(cnt_rdata == snap, "R10", cnt_rdata, snap);
      cnt_rd = 1'b0; step(2);
    end

    // R7 write while running
    cur_req = "R7";
    wr_ctrl(8'hA0);
    wr_pre(8'hF8);
    wr_ctrl(8'hB0);
    step(3);
    snap = cnt_rdata;
    wr_pre(8'h80);
    check(cnt_rdata != 8'h80, "R7", cnt_rdata, snap + 1);
    step(300);

    // R5 masked interrupt
    cur_req = "R5";
    wr_ctrl(8'h90);
    irq_seen = 0;
    ovf_before = m_ovf_total;
    step(400);
    check(irq_seen == 0, "R5", irq_seen, 0);
    check(m_ovf_total > ovf_before, "R5", m_ovf_total, ovf_before + 1);

    // R3 event mode, rising then falling, steady level ignored
    cur_req = "R3";
    wr_ctrl(8'h20);
    wr_pre(8'hFC);
    wr_ctrl(8'h70);
    pulse_ext(3, 4, 10);
    ext_in = 1'b1; step(30);
    snap = cnt_rdata;
    step(20);
    check(cnt_rdata == snap, "R3", cnt_rdata, snap);
    ext_in = 1'b0; step(5);
    wr_ctrl(8'h78);
    pulse_ext(2, 5, 10);

    // R8 pulse width measurement
    cur_req = "R8";
    wr_ctrl(8'h20);
    wr_pre(8'h00);
    wr_ctrl(8'hF0);
    step(6);
    check(ctrl_rdata[4] == 1'b1, "R8", ctrl_rdata, 8'hF0);
    ext_in = 1'b1; step(30);
    ext_in = 1'b0; step(10);
    check(ctrl_rdata[4] == 1'b0, "R8", ctrl_rdata, 8'hE0);
    check(cnt_rdata >= 8'd28 && cnt_rdata <= 8'd32, "R8", cnt_rdata, 30);
    // active-low measurement
    wr_ctrl(8'h20);
    wr_pre(8'h00);
    ext_in = 1'b1; step(4);
    wr_ctrl(8'hF9);
    step(3);
    ext_in = 1'b0; step(40);
    ext_in = 1'b1; step(10);

    // R9 mode off with run set
    cur_req = "R9";
    wr_ctrl(8'h30);
    snap = cnt_rdata;
    pulse_ext(2, 2, 5);
    step(20);
    check(cnt_rdata == snap, "R9", cnt_rdata, snap);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule